// File: doc/BRIEF.md
# Program Bank Controller with 16-bit Interval Timer

This block sits on the write side of an 8-bit CPU bus in a cartridge-style memory system. It watches for writes into a 16-byte register window and turns them into four 8 KB program-memory bank numbers and a 2-bit nametable layout code. The two lower windows follow an outer one-bit select plus a 16 KB page register. The two upper windows are fixed to the last 16 KB of the outer half chosen by a second one-bit select.

The block also contains a 16-bit down-counting interval timer. Software loads its reload value one byte at a time. The value moves into the counter only when the timer-control register is written, and that write also sets the enable and clears a pending interrupt. The counter steps on a per-CPU-cycle tick input. When it reaches zero it raises an active-high interrupt line, and that line stays high until the next timer-control write.

The write bus carries no valid/ready pair. A write is one cycle with `wr_en` high, and the block accepts it in that cycle, so the bus has no back-pressure. Bank numbers and the layout code are plain levels that the block drives continuously.

Top module: `bank_irq_ctrl`

## Requirements
- R1: A write changes nothing unless address bits [15:4] equal the window base (0x800 by default). Inside the window, offsets 0xD, 0xE and 0xF are accepted and have no effect on any output or on the timer.
- R2: A write to offsets 0x0 to 0x3 stores data bit 0 as the lower select. Window 0 then reads lower_select*32 + page*2, and window 1 reads that value plus 1.
- R3: A write to offsets 0x4 to 0x7 stores data bit 0 as the upper select. Window 2 then reads upper_select*32 + 30, and window 3 reads upper_select*32 + 31.
- R4: A write to offset 0x8 stores the whole data byte as the page register. The page is used, doubled, in windows 0 and 1.
- R5: A bank or layout write shows on the outputs from the first clock edge that captures it. No extra cycle of delay is added.
- R6: A write to offset 0x9 takes data bits [1:0] as the layout code, where 0 = vertical, 1 = horizontal, 2 = single-screen low and 3 = single-screen high. The code is driven on `mirror` unchanged.
- R7: A write to offset 0xB replaces the reload value's low byte, and a write to offset 0xC replaces its high byte. In both cases the other byte is kept.
- R8: A write to offset 0xA sets the timer enable from data bit 0, copies the reload value into the counter and clears `irq` at the same edge. When a tick arrives in the same cycle, the write takes precedence.
- R9: While enabled, each tick decrements a nonzero counter. The tick that brings the counter to zero raises `irq`, so a reload value N > 0 fires on the N-th tick and a reload value of 0 fires on the first tick. While the timer is disabled, ticks do nothing.
- R10: Once raised, `irq` stays high through any number of further ticks and other writes until the next write to offset 0xA.
- R11: After reset the selects, page, reload value, counter and enable are all zero, `irq` is low and `mirror` is 0 (vertical). The windows therefore read 0, 1, 30 and 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| tick | input | 1 | One pulse per CPU cycle, clocks the timer |
| bank0 | output | 10 | Bank number of program window 0 |
| bank1 | output | 10 | Bank number of program window 1 |
| bank2 | output | 10 | Bank number of program window 2 |
| bank3 | output | 10 | Bank number of program window 3 |
| mirror | output | 2 | Nametable layout code |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every result is due one clock edge after its stimulus. The register or timer state updates at the edge that samples the write or tick, and the bank numbers are combinational from that state, so all outputs are valid at the falling edge that follows. The driver applies inputs just after a rising edge. For each applied cycle it pushes the expected outputs, tagged with the cycle count at which they become due. The monitor compares at falling edges only the entries whose due count has arrived, so no comparison depends on process order at an edge. The timer's reload and counter are never read directly. They are judged by the exact tick on which `irq` rises.

// File: rtl/bic_pkg.sv
package bic_pkg;

  // Register offsets inside the 16-byte window
  localparam logic [3:0] OFS_PAGE   = 4'h8;
  localparam logic [3:0] OFS_LAYOUT = 4'h9;
  localparam logic [3:0] OFS_TCTL   = 4'hA;
  localparam logic [3:0] OFS_RLD_LO = 4'hB;
  localparam logic [3:0] OFS_RLD_HI = 4'hC;

  typedef enum logic [1:0] {
    LAYOUT_VERT    = 2'd0,
    LAYOUT_HORZ    = 2'd1,
    LAYOUT_ONE_LOW = 2'd2,
    LAYOUT_ONE_HI  = 2'd3
  } layout_e;

  typedef struct packed {
    logic lo_sel;
    logic hi_sel;
    logic page;
    logic layout;
    logic tctl;
    logic rld_lo;
    logic rld_hi;
  } strobe_t;

endpackage

// File: rtl/bic_decode.sv
module bic_decode #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output bic_pkg::strobe_t  strb
);
  import bic_pkg::*;

  localparam int OFS_W = 4;

  logic             in_win;
  logic [OFS_W-1:0] ofs;

  assign in_win = wr_en && (wr_addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
  assign ofs    = wr_addr[OFS_W-1:0];

  always_comb begin
    strb = '0;
    if (in_win) begin
      unique case (ofs)
        4'h0, 4'h1, 4'h2, 4'h3: strb.lo_sel = 1'b1;
        4'h4, 4'h5, 4'h6, 4'h7: strb.hi_sel = 1'b1;
        OFS_PAGE:               strb.page   = 1'b1;
        OFS_LAYOUT:             strb.layout = 1'b1;
        OFS_TCTL:               strb.tctl   = 1'b1;
        OFS_RLD_LO:             strb.rld_lo = 1'b1;
        OFS_RLD_HI:             strb.rld_hi = 1'b1;
        default:                strb        = '0; // 0xD..0xF: accepted, no effect
      endcase
    end
  end

endmodule

// File: rtl/bic_ctrl_regs.sv
module bic_ctrl_regs #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bic_pkg::strobe_t  strb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              lo_sel,
  output logic              hi_sel,
  output logic [PAGE_W-1:0] page,
  output bic_pkg::layout_e  layout
);
  import bic_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_sel <= 1'b0;
      hi_sel <= 1'b0;
      page   <= '0;
      layout <= LAYOUT_VERT;
    end else begin
      if (strb.lo_sel) lo_sel <= wr_data[0];
      if (strb.hi_sel) hi_sel <= wr_data[0];
      if (strb.page)   page   <= wr_data[PAGE_W-1:0];
      if (strb.layout) layout <= layout_e'(wr_data[1:0]);
    end
  end

endmodule

// File: rtl/bic_bank_map.sv
module bic_bank_map #(
  parameter int PAGE_W       = 8,
  parameter int OUTER_STRIDE = 32,
  parameter int NUM_WIN      = 4,
  parameter int BANK_W       = 10
) (
  input  logic              lo_sel,
  input  logic              hi_sel,
  input  logic [PAGE_W-1:0] page,
  output logic [BANK_W-1:0] bank [NUM_WIN]
);

  localparam int HALF = NUM_WIN / 2;

  logic [BANK_W-1:0] lo_base;
  logic [BANK_W-1:0] hi_base;

  assign lo_base = (lo_sel ? BANK_W'(OUTER_STRIDE) : '0) + (BANK_W'(page) << 1);
  assign hi_base = (hi_sel ? BANK_W'(OUTER_STRIDE) : '0) + BANK_W'(OUTER_STRIDE - HALF);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w < HALF) begin : g_paged
      assign bank[w] = lo_base + BANK_W'(w);
    end else begin : g_fixed
      assign bank[w] = hi_base + BANK_W'(w - HALF);
    end
  end

endmodule

// File: rtl/bic_timer.sv
module bic_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tctl_wr,
  input  logic              rld_lo_wr,
  input  logic              rld_hi_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             enable;
  logic             at_zero;
  logic [CNT_W-1:0] count_dec;

  assign at_zero   = (count == '0);
  assign count_dec = count - CNT_W'(1);

  // Reload value: each byte written on its own, the other byte held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= '0;
    end else begin
      if (rld_lo_wr) reload[DATA_W-1:0]     <= wr_data;
      if (rld_hi_wr) reload[CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
    end
  end

  // Counter, enable and sticky interrupt; a control write beats a tick
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      enable <= 1'b0;
      irq    <= 1'b0;
    end else if (tctl_wr) begin
      enable <= wr_data[0];
      count  <= reload;
      irq    <= 1'b0;
    end else if (tick && enable) begin
      if (at_zero) begin
        irq <= 1'b1;
      end else begin
        count <= count_dec;
        if (count_dec == '0) irq <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl #(
  parameter int                ADDR_W       = 16,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE     = 16'h8000,
  parameter int                PAGE_W       = 8,
  parameter int                OUTER_STRIDE = 32,
  parameter int                CNT_W        = 16,
  parameter int                BANK_W       = $clog2(OUTER_STRIDE + (2 ** PAGE_W) * 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [BANK_W-1:0] bank0,
  output logic [BANK_W-1:0] bank1,
  output logic [BANK_W-1:0] bank2,
  output logic [BANK_W-1:0] bank3,
  output logic [1:0]        mirror,
  output logic              irq
);
  import bic_pkg::*;

  localparam int NUM_WIN = 4;

  strobe_t           strb;
  logic              lo_sel;
  logic              hi_sel;
  logic [PAGE_W-1:0] page;
  layout_e           layout;
  logic [BANK_W-1:0] bank [NUM_WIN];

  bic_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strb    (strb)
  );

  bic_ctrl_regs #(
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wr_data (wr_data),
    .lo_sel  (lo_sel),
    .hi_sel  (hi_sel),
    .page    (page),
    .layout  (layout)
  );

  bic_bank_map #(
    .PAGE_W       (PAGE_W),
    .OUTER_STRIDE (OUTER_STRIDE),
    .NUM_WIN      (NUM_WIN),
    .BANK_W       (BANK_W)
  ) u_map (
    .lo_sel (lo_sel),
    .hi_sel (hi_sel),
    .page   (page),
    .bank   (bank)
  );

  bic_timer #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tctl_wr   (strb.tctl),
    .rld_lo_wr (strb.rld_lo),
    .rld_hi_wr (strb.rld_hi),
    .wr_data   (wr_data),
    .irq       (irq)
  );

  assign bank0  = bank[0];
  assign bank1  = bank[1];
  assign bank2  = bank[2];
  assign bank3  = bank[3];
  assign mirror = layout;

endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
  parameter int                ADDR_W       = 16,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE     = 16'h8000,
  parameter int                OUTER_STRIDE = 32,
  parameter int                BANK_W       = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic [BANK_W-1:0] bank0,
  input logic [BANK_W-1:0] bank1,
  input logic [BANK_W-1:0] bank2,
  input logic [BANK_W-1:0] bank3,
  input logic [1:0]        mirror,
  input logic              irq
);

  logic win_hit;
  logic ctl_hit;

  assign win_hit = wr_en && (wr_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
  assign ctl_hit = win_hit && (wr_addr[3:0] == 4'hA);

  assert_outside_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |=> ($stable(bank0) && $stable(bank1) && $stable(bank2)
                  && $stable(bank3) && $stable(mirror)));

  assert_hi_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && wr_addr[3:2] == 2'b01) |=>
      (bank2 == ($past(wr_data[0]) ? BANK_W'(2 * OUTER_STRIDE - 2) : BANK_W'(OUTER_STRIDE - 2))));

  assert_page_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && wr_addr[3:0] == 4'h8) |=> (bank0[0] == 1'b0));

  assert_layout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && wr_addr[3:0] == 4'h9) |=> (mirror == $past(wr_data[1:0])));

  assert_ctl_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> !irq);

  assert_rise_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_hit) |=> irq);

endmodule

bind bank_irq_ctrl bic_checker #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .WIN_BASE     (WIN_BASE),
  .OUTER_STRIDE (OUTER_STRIDE),
  .BANK_W       (BANK_W)
) u_bic_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .tick    (tick),
  .bank0   (bank0),
  .bank1   (bank1),
  .bank2   (bank2),
  .bank3   (bank3),
  .mirror  (mirror),
  .irq     (irq)
);

// File: tb/tb_bank_irq_ctrl.sv
`timescale 1ns/1ps
module tb_bank_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic [9:0]  bank0, bank1, bank2, bank3;
  logic [1:0]  mirror;
  logic        irq;

  always #10 clk = ~clk; // 50 MHz

  bank_irq_ctrl dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .tick (tick), .bank0 (bank0), .bank1 (bank1),
    .bank2 (bank2), .bank3 (bank3), .mirror (mirror), .irq (irq)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard: expected output vector {b0,b1,b2,b3,mirror,irq}, due cycle, tag
  logic [42:0] exp_q [$];
  int          due_q [$];
  string       tag_q [$];

  // Reference state built from the requirements
  bit          m_lo, m_hi, m_en, m_irq;
  logic [7:0]  m_page;
  logic [1:0]  m_mir;
  logic [15:0] m_rld, m_cnt;

  function automatic logic [42:0] model_vec();
    logic [9:0] b0, b2;
    b0 = (m_lo ? 10'd32 : 10'd0) + {1'b0, m_page, 1'b0};
    b2 = (m_hi ? 10'd32 : 10'd0) + 10'd30;
    return {b0, b0 + 10'd1, b2, b2 + 10'd1, m_mir, m_irq};
  endfunction

  function automatic logic [42:0] dut_vec();
    return {bank0, bank1, bank2, bank3, mirror, irq};
  endfunction

  task automatic compare(input logic [42:0] exp, input string tag);
    checks++;
    if (dut_vec() !== exp) begin
      fails++;
      $display("FAIL %s: actual b=%0d,%0d,%0d,%0d mir=%0d irq=%0b expected b=%0d,%0d,%0d,%0d mir=%0d irq=%0b",
               tag, bank0, bank1, bank2, bank3, mirror, irq,
               exp[42:33], exp[32:23], exp[22:13], exp[12:3], exp[2:1], exp[0]);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the outputs due after it
  task automatic step(input bit we, input logic [15:0] a, input logic [7:0] d,
                      input bit tk, input string tag);
    bit in_win;
    @(posedge clk);
    #1;
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    in_win = we && (a[15:4] == 12'h800);
    if (in_win && a[3:0] == 4'hA) begin
      m_en = d[0]; m_cnt = m_rld; m_irq = 1'b0;
    end else begin
      if (in_win) begin
        case (a[3:0])
          4'h0, 4'h1, 4'h2, 4'h3: m_lo = d[0];
          4'h4, 4'h5, 4'h6, 4'h7: m_hi = d[0];
          4'h8: m_page = d;
          4'h9: m_mir = d[1:0];
          4'hB: m_rld[7:0] = d;
          4'hC: m_rld[15:8] = d;
          default: ;
        endcase
      end
      if (tk && m_en) begin
        if (m_cnt == 16'd0) m_irq = 1'b1;
        else begin
          m_cnt = m_cnt - 16'd1;
          if (m_cnt == 16'd0) m_irq = 1'b1;
        end
      end
    end
    exp_q.push_back(model_vec());
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 8'h00, 1'b1, tag);
  endtask

  // Monitor: compare entries whose due cycle has arrived
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      compare(exp_q[0], tag_q[0]);
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run still active, actual hung expected finished");
    finish_run();
  end

  initial begin
    m_lo = 0; m_hi = 0; m_en = 0; m_irq = 0; m_page = 0; m_mir = 0; m_rld = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(model_vec(), "R11 reset state"); // 0,1,30,31, vertical, irq low
    @(posedge clk); #1; rst_n = 1'b1;

    // Bank mapping
    wr(16'h8002, 8'h01, "R2 lower select via offset 2");
    wr(16'h8008, 8'h05, "R4 page 5 -> 42/43");
    wr(16'h8006, 8'hFF, "R3 upper select via offset 6 -> 62/63");
    wr(16'h8008, 8'hFF, "R4 page 255 -> 542/543");
    wr(16'h8001, 8'hFE, "R2 lower select cleared by bit0 only");
    wr(16'h8004, 8'h00, "R3 upper select cleared");
    wr(16'h8008, 8'h80, "R5 page change visible next edge");

    // Decode window and dead offsets
    wr(16'h9008, 8'h00, "R1 outside window page write");
    wr(16'h7009, 8'h03, "R1 outside window layout write");
    wr(16'h800D, 8'hFF, "R1 offset D ignored");
    wr(16'h800E, 8'hFF, "R1 offset E ignored");
    wr(16'h800F, 8'hFF, "R1 offset F ignored");

    // Layout codes
    wr(16'h8009, 8'hFD, "R6 layout horizontal");
    wr(16'h8009, 8'h02, "R6 layout single low");
    wr(16'h8009, 8'h07, "R6 layout single high");
    wr(16'h8009, 8'h00, "R6 layout vertical");

    // Timer: reload 3
    wr(16'h800C, 8'h00, "R7 reload high byte");
    wr(16'h800B, 8'h03, "R7 reload low byte");
    ticks(2, "R9 disabled ticks no irq");
    wr(16'h800A, 8'h01, "R8 enable and load");
    ticks(3, "R9 three ticks fire on third");
    ticks(4, "R10 irq held through ticks");
    wr(16'h8008, 8'h11, "R10 irq held through other write");
    step(1'b1, 16'h800A, 8'h00, 1'b1, "R8 control write beats tick, clears irq");
    ticks(5, "R9 disabled no counting");

    // Byte preservation: high 0x01 then low 0x02 -> 258
    wr(16'h800C, 8'h01, "R7 high byte 1");
    wr(16'h800B, 8'h02, "R7 low byte keeps high");
    wr(16'h800A, 8'h01, "R8 load 258");
    ticks(258, "R7 fires exactly at 258");
    wr(16'h800D, 8'h01, "R1 offset D leaves irq");

    // Zero reload fires on first tick
    wr(16'h800C, 8'h00, "R7 clear high");
    wr(16'h800B, 8'h00, "R7 clear low");
    wr(16'h800A, 8'h01, "R8 load zero");
    step(1'b0, 16'h0000, 8'h00, 1'b0, "R9 no tick no irq");
    ticks(1, "R9 zero reload fires on first tick");
    wr(16'h800A, 8'h01, "R10 cleared only by control write");

    step(1'b0, 16'h0000, 8'h00, 1'b0, "idle");
    step(1'b0, 16'h0000, 8'h00, 1'b0, "idle");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule